// File: doc/BRIEF.md
# Current-Source Rotation and Trim Router

This block drives the switch-control word for six matched unit current sources (nominally 2 µA each) that bias two diode-connected bipolar transistors, Q1 and Q2, in a temperature-sensor front end. Each source has a 2-bit route select that sends it to Q1, to Q2, or to a dummy diode sink, so that no source is ever left floating.

There are two modes. In ratio mode, used to build the base-emitter voltage difference, one source feeds Q1 and the other five feed Q2, giving a 1:5 current ratio. The single source rotates on every modulator cycle, so source mismatch averages out over a conversion. In absolute mode, used for the plain base-emitter voltage, a coarse code sets how many of the first five sources feed Q1. The sixth source carries a 4-bit fine DAC code at 64 nA per step. Sources that are not needed go to the dummy sink.

All state and outputs update on a clock edge where the modulator-cycle enable is high. The mode, coarse code and fine code are sampled on that same edge.

Top module: `isrc_route_sel`

## Requirements
- R1: During and after reset, and until the first enabled cycle, every route field is 00 (dummy), `fine_dac` is 0, and the rotation pointer is at source 0.
- R2: After an enabled cycle with `mode_abs`=0, exactly one route field is 01 (Q1) and the other five are 10 (Q2). Source i uses bits [2i+1:2i] of `route_sel`.
- R3: The k-th ratio-mode enabled cycle (k counted from 1, with only ratio cycles counted since reset) makes source (k-1) mod 6 the single Q1 source. Across any 6 consecutive ratio cycles, each source is the single source exactly once.
- R4: While `cyc_en` is low, `route_sel` and `fine_dac` hold their values whatever `mode_abs`, `coarse_code` and `fine_code` do.
- R5: After an enabled cycle with `mode_abs`=1, sources 0..4 with index below min(`coarse_code`, 5) are 01 (Q1) and the rest of sources 0..4 are 00 (dummy). Codes 6 and 7 act as 5. No field is 10.
- R6: After an enabled absolute-mode cycle, `fine_dac` equals `fine_code`, and source 5 is 01 when `fine_code` is nonzero and 00 when it is zero. After an enabled ratio-mode cycle, `fine_dac` is 0.
- R7: No route field ever carries the code 11.
- R8: Absolute-mode cycles do not advance the rotation pointer. The next ratio cycle continues the sequence where the last ratio cycle left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Modulator-cycle enable; one pulse per modulator cycle |
| mode_abs | input | 1 | 0 = rotating ratio mode, 1 = absolute trimmed mode |
| coarse_code | input | 3 | Number of sources 0..4 sent to Q1 in absolute mode (saturates at 5) |
| fine_code | input | 4 | Fine DAC code for source 5 in absolute mode |
| route_sel | output | 12 | Two bits per source: 00 dummy, 01 Q1, 10 Q2 |
| fine_dac | output | 4 | Registered fine DAC code |

## Verification
The bench builds the block with its default values: six sources, a 3-bit coarse code and a 4-bit fine code. With six sources a full rotation takes only six enabled cycles, so wrap-around and the "each source once" property are checked directly. The 3-bit coarse code reaches the two codes above five, which exercises saturation. The 4-bit fine code covers the zero, one and full-scale values that decide whether source 5 is parked or active.

// File: rtl/isrc_sel_pkg.sv
package isrc_sel_pkg;

    localparam int SRC_COUNT   = 6;
    localparam int COARSE_BITS = 3;
    localparam int FINE_BITS   = 4;

    typedef enum logic [1:0] {
        RT_DUMMY = 2'b00,
        RT_Q1    = 2'b01,
        RT_Q2    = 2'b10
    } route_e;

    typedef enum logic {
        MD_RATIO = 1'b0,
        MD_ABS   = 1'b1
    } mode_e;

    // Clamp a requested source count to the number available.
    function automatic int unsigned clamp_count(input int unsigned req,
                                                input int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/isrc_dem_ptr.sv
module isrc_dem_ptr #(
    parameter int N_SRC = isrc_sel_pkg::SRC_COUNT,
    localparam int PW = $clog2(N_SRC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(N_SRC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/isrc_ratio_map.sv
module isrc_ratio_map
    import isrc_sel_pkg::*;
#(
    parameter int N_SRC = SRC_COUNT,
    localparam int PW = $clog2(N_SRC)
) (
    input  logic [PW-1:0]          ptr,
    output logic [N_SRC-1:0][1:0]  rt
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign rt[i] = (ptr == PW'(i)) ? RT_Q1 : RT_Q2;
    end
endmodule

// File: rtl/isrc_trim_map.sv
module isrc_trim_map
    import isrc_sel_pkg::*;
#(
    parameter int N_SRC    = SRC_COUNT,
    parameter int COARSE_W = COARSE_BITS,
    parameter int FINE_W   = FINE_BITS,
    localparam int NC = N_SRC - 1
) (
    input  logic [COARSE_W-1:0]    coarse,
    input  logic [FINE_W-1:0]      fine,
    output logic [N_SRC-1:0][1:0]  rt
);
    logic [COARSE_W:0] cnt;

    always_comb begin
        cnt = (COARSE_W+1)'(clamp_count(int'(coarse), NC));
    end

    for (genvar i = 0; i < NC; i++) begin : g_coarse
        assign rt[i] = ((COARSE_W+1)'(i) < cnt) ? RT_Q1 : RT_DUMMY;
    end

    assign rt[NC] = (fine != '0) ? RT_Q1 : RT_DUMMY;
endmodule

// File: rtl/isrc_route_sel.sv
module isrc_route_sel
    import isrc_sel_pkg::*;
#(
    parameter int N_SRC    = SRC_COUNT,
    parameter int COARSE_W = COARSE_BITS,
    parameter int FINE_W   = FINE_BITS,
    localparam int PW = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cyc_en,
    input  logic                 mode_abs,
    input  logic [COARSE_W-1:0]  coarse_code,
    input  logic [FINE_W-1:0]    fine_code,
    output logic [2*N_SRC-1:0]   route_sel,
    output logic [FINE_W-1:0]    fine_dac
);
    logic [PW-1:0]          ptr;
    logic [N_SRC-1:0][1:0]  ratio_rt;
    logic [N_SRC-1:0][1:0]  trim_rt;
    logic [N_SRC-1:0][1:0]  route_q;
    logic [FINE_W-1:0]      dac_q;
    mode_e                  mode_q;
    logic                   rot_adv;

    assign rot_adv = cyc_en && !mode_abs;

    isrc_dem_ptr #(.N_SRC(N_SRC)) u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (rot_adv),
        .ptr (ptr)
    );

    isrc_ratio_map #(.N_SRC(N_SRC)) u_ratio (
        .ptr (ptr),
        .rt  (ratio_rt)
    );

    isrc_trim_map #(.N_SRC(N_SRC), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_trim (
        .coarse (coarse_code),
        .fine   (fine_code),
        .rt     (trim_rt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            dac_q   <= '0;
            mode_q  <= MD_RATIO;
        end else if (cyc_en) begin
            mode_q <= mode_e'(mode_abs);
            if (mode_abs) begin
                route_q <= trim_rt;
                dac_q   <= fine_code;
            end else begin
                route_q <= ratio_rt;
                dac_q   <= '0;
            end
        end
    end

    assign route_sel = route_q;
    assign fine_dac  = dac_q;
endmodule

// File: rtl/isrc_route_sel_chk.sv
module isrc_route_sel_chk
    import isrc_sel_pkg::*;
#(
    parameter int N_SRC  = SRC_COUNT,
    parameter int FINE_W = FINE_BITS
) (
    input logic                clk,
    input logic                rst,
    input logic                cyc_en,
    input logic [2*N_SRC-1:0]  route_sel,
    input logic [FINE_W-1:0]   fine_dac,
    input mode_e               mode_q
);
    logic [N_SRC-1:0] q1_mask;
    logic [N_SRC-1:0] q2_mask;

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask
        assign q1_mask[i] = (route_sel[2*i+1 -: 2] == 2'b01);
        assign q2_mask[i] = (route_sel[2*i+1 -: 2] == 2'b10);

        a_r7_no_illegal: assert property (@(posedge clk) disable iff (rst)
            route_sel[2*i+1 -: 2] != 2'b11);
    end

    a_r2_single_q1: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc_en) && !$past(rst) && mode_q == MD_RATIO)
        |-> ($countones(q1_mask) == 1 && $countones(q2_mask) == N_SRC - 1));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(cyc_en) && !$past(rst)) |-> ($stable(route_sel) && $stable(fine_dac)));

    a_r5_no_q2_abs: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc_en) && !$past(rst) && mode_q == MD_ABS) |-> (q2_mask == '0));

    a_r6_dac_zero_ratio: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc_en) && !$past(rst) && mode_q == MD_RATIO) |-> (fine_dac == '0));
endmodule

bind isrc_route_sel isrc_route_sel_chk #(.N_SRC(N_SRC), .FINE_W(FINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_en    (cyc_en),
    .route_sel (route_sel),
    .fine_dac  (fine_dac),
    .mode_q    (mode_q)
);

// File: tb/isrc_route_sel_bench.sv
module isrc_route_sel_bench;
    localparam int N  = 6;
    localparam int CW = 3;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc_en = 1'b0;
    logic          mode_abs = 1'b0;
    logic [CW-1:0] coarse_code = '0;
    logic [FW-1:0] fine_code = '0;
    logic [2*N-1:0] route_sel;
    logic [FW-1:0] fine_dac;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    isrc_route_sel u_isrc_route_sel (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .mode_abs(mode_abs),
        .coarse_code(coarse_code), .fine_code(fine_code),
        .route_sel(route_sel), .fine_dac(fine_dac)
    );

    function automatic logic [2*N-1:0] ratio_word(input int single);
        logic [2*N-1:0] w;
        for (int i = 0; i < N; i++) w[2*i +: 2] = (i == single) ? 2'b01 : 2'b10;
        return w;
    endfunction

    function automatic logic [2*N-1:0] abs_word(input int c, input int f);
        logic [2*N-1:0] w;
        int lim;
        lim = (c > 5) ? 5 : c;
        for (int i = 0; i < 5; i++) w[2*i +: 2] = (i < lim) ? 2'b01 : 2'b00;
        w[11:10] = (f != 0) ? 2'b01 : 2'b00;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_no_illegal();
        int bad;
        bad = 0;
        for (int i = 0; i < N; i++) if (route_sel[2*i +: 2] == 2'b11) bad++;
        check("R7 no code 11", 32'(bad), 32'd0);
    endtask

    task automatic pulse(input logic m, input int c, input int f);
        @(negedge clk);
        mode_abs = m; coarse_code = CW'(c); fine_code = FW'(f); cyc_en = 1'b1;
        @(negedge clk);
        cyc_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset routes dummy", 32'(route_sel), 32'd0);
        check("R1 reset dac zero", 32'(fine_dac), 32'd0);
    endtask

    task automatic t_rotation();
        int seen [N];
        for (int i = 0; i < N; i++) seen[i] = 0;
        for (int k = 0; k < N; k++) begin
            pulse(1'b0, 3, 9);
            check("R2/R3 ratio word", 32'(route_sel), 32'(ratio_word(exp_ptr)));
            check("R6 dac zero in ratio", 32'(fine_dac), 32'd0);
            check_no_illegal();
            for (int i = 0; i < N; i++) if (route_sel[2*i +: 2] == 2'b01) seen[i]++;
            exp_ptr = (exp_ptr + 1) % N;
        end
        for (int i = 0; i < N; i++) check("R3 each source single once", 32'(seen[i]), 32'd1);
    endtask

    task automatic t_hold();
        logic [2*N-1:0] keep;
        pulse(1'b0, 0, 0);
        keep = ratio_word(exp_ptr);
        exp_ptr = (exp_ptr + 1) % N;
        mode_abs = 1'b1; coarse_code = 3'd4; fine_code = 4'd7;
        repeat (3) @(negedge clk);
        check("R4 route held without enable", 32'(route_sel), 32'(keep));
        check("R4 dac held without enable", 32'(fine_dac), 32'd0);
    endtask

    task automatic t_abs_coarse();
        for (int c = 0; c < 8; c++) begin
            pulse(1'b1, c, 0);
            check("R5 coarse routing", 32'(route_sel), 32'(abs_word(c, 0)));
            check_no_illegal();
        end
    endtask

    task automatic t_fine();
        int vals [3] = '{1, 15, 0};
        foreach (vals[j]) begin
            pulse(1'b1, 2, vals[j]);
            check("R6 fine dac value", 32'(fine_dac), 32'(vals[j]));
            check("R6 source 5 routing", 32'(route_sel), 32'(abs_word(2, vals[j])));
        end
    endtask

    task automatic t_resume();
        for (int k = 0; k < 2; k++) begin
            pulse(1'b0, 0, 5);
            check("R8 rotation resumes", 32'(route_sel), 32'(ratio_word(exp_ptr)));
            exp_ptr = (exp_ptr + 1) % N;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rotation();
        t_hold();
        t_abs_coarse();
        t_fine();
        t_resume();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule